// File: doc/BRIEF.md
# Parallel Camera Pixel Word Packer

This block takes samples from a parallel camera bus of up to 14 bits and packs them into 32-bit words for a downstream FIFO or data register. The pixel clock is not used as a clock. It is sampled in the system clock domain, and each falling edge becomes a one-cycle capture enable. A sample is kept only when the line sync and the frame sync are both low. A high level on either sync marks blanking, and samples taken then are dropped.

A two-bit width mode sets how samples are packed:

- **Mode `00`:** four 8-bit samples fill one word.
- **Mode `01`:** two 10-bit samples fill one word. Each 10-bit sample is zero-extended to a 16-bit half.

Packing always starts at the least significant position. A rising edge of the frame sync returns the packer to the first slot, so each frame starts a fresh word. A finished word appears on `word_out`. A single-cycle `word_valid` strobe marks it, and `word_out` holds that value until the next word finishes.

The packer is a four-state machine over the slot position:

- `SLOT_0`, `SLOT_1`, `SLOT_2`, `SLOT_3` are the four slot positions.
- **In mode `00`:** a capture moves `SLOT_0`→`SLOT_1`→`SLOT_2`→`SLOT_3`→`SLOT_0`. The capture in `SLOT_3` completes the word.
- **In mode `01`:** a capture moves `SLOT_0`→`SLOT_1`→`SLOT_0`. The capture in `SLOT_1` completes the word.
- **Frame restart:** a rising frame sync forces any state to `SLOT_0`.
- **No capture:** the state holds.

Top module: `cam_word_packer`

## Requirements
- R1: After reset, `word_valid` is 0 and `word_out` is 0.
- R2: A sample is taken only at a falling edge of `pix_clk`, using the `pix_data` value present at that edge. Data seen at the rising edge, or while the clock level holds, is not captured.
- R3: A falling edge of `pix_clk` while `line_sync` or `frame_sync` is high captures nothing and produces no word.
- R4: With `width_mode` = `00`, only `pix_data[7:0]` is used, and bits 13:8 have no effect. Four captures complete a word, with the first in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R5: With `width_mode` = `01`, only `pix_data[9:0]` is used. Two captures complete a word, with the first in bits 9:0 and the second in bits 25:16. Bits 15:10 and 31:26 are 0.
- R6: `word_valid` is a single-cycle pulse, high in the cycle after the capture that completes a word. `word_out` changes only together with that pulse and holds otherwise.
- R7: A rising edge of `frame_sync` discards any partly filled word, and the next capture goes to the first slot.
- R8: With `width_mode` = `10` or `11`, no sample is captured and no word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_clk | input | 1 | Camera pixel clock, sampled as data |
| line_sync | input | 1 | Horizontal sync, high during line blanking |
| frame_sync | input | 1 | Vertical sync, high during frame blanking |
| pix_data | input | 14 | Camera data bus |
| width_mode | input | 2 | 00 = 8-bit, 01 = 10-bit, 10/11 unsupported |
| word_out | output | 32 | Last completed packed word |
| word_valid | output | 1 | One-cycle strobe for a new word |

## Verification
The bench builds the block with its default parameters: a 14-bit data bus and 32-bit words. The full bus width lets the bench drive ones on the bits above the selected sample width, so it can show that each mode discards them. The default word width puts all four byte slots and both half-word slots within reach. The bench also uses a pixel clock several system cycles long, so a data change after the rising edge can be told apart from the value captured at the falling edge.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    localparam int BYTE_W   = 8;
    localparam int TEN_W    = 10;
    localparam int HALF_W   = 16;
    localparam int PACK_W   = 32;
    localparam int LANES    = PACK_W / BYTE_W;
    localparam int HALVES   = PACK_W / HALF_W;

    typedef enum logic [1:0] {
        SLOT_0 = 2'd0,
        SLOT_1 = 2'd1,
        SLOT_2 = 2'd2,
        SLOT_3 = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        WM_BYTE   = 2'b00,
        WM_TENBIT = 2'b01,
        WM_RSV_A  = 2'b10,
        WM_RSV_B  = 2'b11
    } wmode_e;

endpackage

// File: rtl/cwp_sync_detect.sv
module cwp_sync_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic line_sync,
    input  logic frame_sync,
    output logic pix_fall,
    output logic frame_rise,
    output logic active_region
);

    logic pclk_q;
    logic fsync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_q  <= 1'b0;
            fsync_q <= 1'b0;
        end else begin
            pclk_q  <= pix_clk;
            fsync_q <= frame_sync;
        end
    end

    // Edges are found against the previous system-clock sample
    assign pix_fall      = pclk_q & ~pix_clk;
    assign frame_rise    = frame_sync & ~fsync_q;
    assign active_region = ~line_sync & ~frame_sync;

endmodule

// File: rtl/cwp_sample_fmt.sv
module cwp_sample_fmt
    import cwp_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic [DATA_W-1:0] pix_data,
    input  logic [1:0]        width_mode,
    output logic [BYTE_W-1:0] byte_sample,
    output logic [HALF_W-1:0] half_sample,
    output logic              mode_ok,
    output logic              is_tenbit
);

    localparam int PAD_W = HALF_W - TEN_W;

    logic unused_hi_bits;
    assign unused_hi_bits = ^pix_data[DATA_W-1:TEN_W];

    assign byte_sample = pix_data[BYTE_W-1:0];
    assign half_sample = {{PAD_W{1'b0}}, pix_data[TEN_W-1:0]};

    always_comb begin
        mode_ok   = 1'b0;
        is_tenbit = 1'b0;
        unique case (wmode_e'(width_mode))
            WM_BYTE:   mode_ok = 1'b1;
            WM_TENBIT: begin
                mode_ok   = 1'b1;
                is_tenbit = 1'b1;
            end
            WM_RSV_A:  mode_ok = 1'b0;
            WM_RSV_B:  mode_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/cwp_pack_fsm.sv
module cwp_pack_fsm
    import cwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              frame_rise,
    input  logic              is_tenbit,
    input  logic [BYTE_W-1:0] byte_sample,
    input  logic [HALF_W-1:0] half_sample,
    output logic [PACK_W-1:0] word_out,
    output logic              word_valid
);

    slot_e             state;
    slot_e             state_nx;
    logic              word_done;
    logic [PACK_W-1:0] acc;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_0;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx  = state;
        word_done = 1'b0;
        if (frame_rise) begin
            state_nx = SLOT_0;
        end else if (capture) begin
            unique case (state)
                SLOT_0: state_nx = SLOT_1;
                SLOT_1: begin
                    state_nx  = is_tenbit ? SLOT_0 : SLOT_2;
                    word_done = is_tenbit;
                end
                SLOT_2: begin
                    state_nx  = is_tenbit ? SLOT_0 : SLOT_3;
                    word_done = is_tenbit;
                end
                SLOT_3: begin
                    state_nx  = SLOT_0;
                    word_done = 1'b1;
                end
            endcase
        end
    end

    // Outputs and packing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= word_done;
            if (capture && !frame_rise) begin
                if (is_tenbit) begin
                    if (state == SLOT_0) acc[HALF_W-1:0] <= half_sample;
                end else begin
                    acc[BYTE_W*state +: BYTE_W] <= byte_sample;
                end
            end
            if (word_done) begin
                if (is_tenbit)
                    word_out <= {half_sample, acc[HALF_W-1:0]};
                else
                    word_out <= {byte_sample, acc[PACK_W-BYTE_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/cam_word_packer.sv
module cam_word_packer
    import cwp_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_clk,
    input  logic              line_sync,
    input  logic              frame_sync,
    input  logic [DATA_W-1:0] pix_data,
    input  logic [1:0]        width_mode,
    output logic [PACK_W-1:0] word_out,
    output logic              word_valid
);

    logic              pix_fall;
    logic              frame_rise;
    logic              active_region;
    logic [BYTE_W-1:0] byte_sample;
    logic [HALF_W-1:0] half_sample;
    logic              mode_ok;
    logic              is_tenbit;
    logic              capture;

    cwp_sync_detect u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .pix_clk       (pix_clk),
        .line_sync     (line_sync),
        .frame_sync    (frame_sync),
        .pix_fall      (pix_fall),
        .frame_rise    (frame_rise),
        .active_region (active_region)
    );

    cwp_sample_fmt #(.DATA_W(DATA_W)) u_fmt (
        .pix_data    (pix_data),
        .width_mode  (width_mode),
        .byte_sample (byte_sample),
        .half_sample (half_sample),
        .mode_ok     (mode_ok),
        .is_tenbit   (is_tenbit)
    );

    assign capture = pix_fall & active_region & mode_ok;

    cwp_pack_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .frame_rise  (frame_rise),
        .is_tenbit   (is_tenbit),
        .byte_sample (byte_sample),
        .half_sample (half_sample),
        .word_out    (word_out),
        .word_valid  (word_valid)
    );

endmodule

// File: rtl/cwp_checker.sv
module cwp_checker #(
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_clk,
    input logic              line_sync,
    input logic              frame_sync,
    input logic [DATA_W-1:0] pix_data,
    input logic [1:0]        width_mode,
    input logic [31:0]       word_out,
    input logic              word_valid
);

    logic [DATA_W-1:0] unused_data;
    assign unused_data = pix_data;

    // R6
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));

    // R3
    blank_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sync || frame_sync) |=> !word_valid);

    // R8
    rsvd_mode_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        width_mode[1] |=> !word_valid);

    // R2
    fall_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_clk |=> !word_valid);

    // R5
    tenbit_zero_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width_mode == 2'b01) ##1 word_valid |->
            (word_out[15:10] == 6'd0) && (word_out[31:26] == 6'd0));

endmodule

bind cam_word_packer cwp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_clk    (pix_clk),
    .line_sync  (line_sync),
    .frame_sync (frame_sync),
    .pix_data   (pix_data),
    .width_mode (width_mode),
    .word_out   (word_out),
    .word_valid (word_valid)
);

// File: tb/cam_word_packer_tb.sv
module cam_word_packer_tb;

    typedef struct {
        logic [31:0] w;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_clk = 1'b0;
    logic        line_sync = 1'b0;
    logic        frame_sync = 1'b0;
    logic [13:0] pix_data = '0;
    logic [1:0]  width_mode = 2'b00;
    logic [31:0] word_out;
    logic        word_valid;

    int    checks = 0;
    int    fails  = 0;
    exp_t  exp_q[$];
    string cur_tag = "R1";
    int    m_pos = 0;
    logic [31:0] m_acc = '0;
    bit    pulse_err = 0;
    bit    hold_err  = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    cam_word_packer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_clk    (pix_clk),
        .line_sync  (line_sync),
        .frame_sync (frame_sync),
        .pix_data   (pix_data),
        .width_mode (width_mode),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of the expected packing; pushes finished words into the queue
    task automatic model_sample(input logic [13:0] d);
        exp_t e;
        if (width_mode == 2'b00) begin
            m_acc[8*m_pos +: 8] = d[7:0];
            m_pos++;
            if (m_pos == 4) begin
                e.w = m_acc; e.tag = cur_tag; exp_q.push_back(e);
                m_pos = 0;
            end
        end else if (width_mode == 2'b01) begin
            if (m_pos == 0) begin
                m_acc = {22'd0, d[9:0]};
                m_pos = 1;
            end else begin
                e.w = {6'd0, d[9:0], m_acc[15:0]}; e.tag = cur_tag; exp_q.push_back(e);
                m_pos = 0;
            end
        end
    endtask

    // One pixel clock period; rise_d is shown at the rising edge, d at the fall
    task automatic pix_cycle2(input logic [13:0] rise_d, input logic [13:0] d, input logic hs, input logic vs);
        @(negedge clk);
        if (vs && !frame_sync) m_pos = 0;
        line_sync = hs; frame_sync = vs;
        pix_clk = 1'b1; pix_data = rise_d;
        repeat (2) @(negedge clk);
        pix_data = d;
        @(negedge clk);
        if (!hs && !vs) model_sample(d);
        pix_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pix_cycle(input logic [13:0] d, input logic hs, input logic vs);
        pix_cycle2(d, d, hs, vs);
    endtask

    task automatic drain(input string tag);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
    endtask

    // Monitor: pops expected words as the design delivers them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (word_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected word"}, word_out, 32'hx);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(word_out === e.w, e.tag, word_out, e.w);
                end
            end
        end
    end

    logic        prev_valid = 1'b0;
    logic [31:0] prev_word  = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid && prev_valid) pulse_err = 1;
            if (!word_valid && word_out !== prev_word) hold_err = 1;
        end
        prev_valid = word_valid;
        prev_word  = word_out;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(word_valid === 1'b0, "R1 valid", 32'(word_valid), 32'd0);
        check(word_out === 32'd0, "R1 word", word_out, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 byte packing with junk on bits 13:8
        cur_tag = "R4";
        pix_cycle(14'h3F11, 0, 0);
        pix_cycle(14'h2A22, 0, 0);
        pix_cycle(14'h1533, 0, 0);
        pix_cycle(14'h3F44, 0, 0);
        pix_cycle(14'h00A5, 0, 0);
        pix_cycle(14'h3FFF, 0, 0);
        pix_cycle(14'h0000, 0, 0);
        pix_cycle(14'h2C5A, 0, 0);
        drain("R4 drained");

        // R2 data changed between rise and fall: fall value must win
        cur_tag = "R2";
        pix_cycle2(14'h00EE, 14'h0001, 0, 0);
        pix_cycle2(14'h00EE, 14'h0002, 0, 0);
        pix_cycle2(14'h00EE, 14'h0003, 0, 0);
        pix_cycle2(14'h00EE, 14'h0004, 0, 0);
        drain("R2 drained");

        // R3 blanking samples dropped
        cur_tag = "R3";
        pix_cycle(14'h0010, 0, 0);
        pix_cycle(14'h00BB, 1, 0);
        pix_cycle(14'h0020, 0, 0);
        pix_cycle(14'h00CC, 1, 0);
        pix_cycle(14'h0030, 0, 0);
        pix_cycle(14'h0040, 0, 0);
        drain("R3 drained");

        // R7 partial word discarded on frame start
        cur_tag = "R7";
        pix_cycle(14'h0077, 0, 0);
        pix_cycle(14'h0088, 0, 0);
        pix_cycle(14'h00DD, 0, 1);
        pix_cycle(14'h00DD, 1, 1);
        pix_cycle(14'h0091, 0, 0);
        pix_cycle(14'h0092, 0, 0);
        pix_cycle(14'h0093, 0, 0);
        pix_cycle(14'h0094, 0, 0);
        drain("R7 drained");

        // R5 ten-bit packing with junk on bits 13:10
        cur_tag = "R5";
        @(negedge clk) width_mode = 2'b01;
        pix_cycle(14'h3FFF, 0, 0);
        pix_cycle(14'h2C01, 0, 0);
        pix_cycle(14'h0155, 0, 0);
        pix_cycle(14'h3E2A, 0, 0);
        pix_cycle(14'h0000, 0, 0);
        pix_cycle(14'h03FF, 0, 0);
        drain("R5 drained");

        // R7 in ten-bit mode
        cur_tag = "R7";
        pix_cycle(14'h0123, 0, 0);
        pix_cycle(14'h0000, 0, 1);
        pix_cycle(14'h0201, 0, 0);
        pix_cycle(14'h0102, 0, 0);
        drain("R7 ten-bit drained");

        // R8 unsupported modes emit nothing
        cur_tag = "R8";
        @(negedge clk) width_mode = 2'b10;
        for (int i = 0; i < 5; i++) pix_cycle(14'(i + 1), 0, 0);
        drain("R8 mode 10");
        @(negedge clk) width_mode = 2'b11;
        for (int i = 0; i < 5; i++) pix_cycle(14'(i + 8), 0, 0);
        drain("R8 mode 11");
        @(negedge clk) width_mode = 2'b00;
        pix_cycle(14'h00C1, 0, 0);
        pix_cycle(14'h00C2, 0, 0);
        pix_cycle(14'h00C3, 0, 0);
        pix_cycle(14'h00C4, 0, 0);
        drain("R8 back to byte mode");

        // R6 pulse width and hold
        check(!pulse_err, "R6 single-cycle strobe", 32'(pulse_err), 32'd0);
        check(!hold_err, "R6 word held between strobes", 32'(hold_err), 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule